// File: doc/BRIEF.md
# Caller-Identity FSK Frame Sequencer

This block produces the serial bit stream for an on-hook caller-identity burst. Message bytes wait in a 64-entry byte buffer that a host fills through a simple write port. A start command, accepted only while the block is enabled, first sends an alternating seizure pattern and then a run of mark bits. After that, each buffered byte goes out as an asynchronous character (a start bit, eight data bits, a stop bit), and every character is followed by a run of flag marks. One bit is presented per baud-tick strobe. A tone stage downstream turns the bits into audio, and it squelches whenever the valid output is low.

The seizure, mark, flag and byte counts are captured when the start command is accepted, as is the output channel. When the last byte has gone out the block stops on its own. It then either mutes or keeps sending marks: the mark-hold mode lets a long message be split into segments, and the line stays seized while the buffer is refilled and restarted. Four channels share the one stream, and a per-channel valid vector shows which channel the stream belongs to.

Top module: `cid_fsk_sequencer`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `bit_valid`, `bit_out` and every `chan_valid` bit are 0.
- R2: A start command is accepted only while `enable` is 1 and `busy` is 0. A start while disabled leaves `busy` and `bit_valid` at 0.
- R3: The stream opens with 2×`seize_pairs` bits alternating 0,1,0,1 (a 0 comes first). A value of 0 omits the seizure.
- R4: After the seizure come `mark_bits` consecutive 1 bits. A value of 0 omits them.
- R5: Each byte is sent as a 0 start bit, then its bits 0 through 7 (bit 0 first), then a 1 stop bit, then `flag_bits` 1 bits.
- R6: Bytes are read from buffer addresses 0 upward. The count is `byte_count` capped at 64. A count of 0 ends the segment directly after the mark run.
- R7: At the end of a segment `busy` falls, `done` is 1 for one cycle, and without mark-hold `bit_valid` is 0 from then on.
- R8: If `mark_hold` is 1 at start and stays 1, then after the segment `bit_valid` stays 1 with `bit_out` 1 and `busy` 0. Clearing `mark_hold` mutes the output on the next cycle.
- R9: Once `mark_hold` has been 0 after a start, setting it to 1 again has no effect until the next accepted start.
- R10: `chan_valid` has at most one bit set. That bit is the channel given by `chan_sel` at start, and it is set exactly when `bit_valid` is 1.
- R11: The stream advances one bit per cycle in which `baud_tick` is 1. Between ticks `bit_out` holds.
- R12: Dropping `enable` aborts any transmission or hold: on the next cycle `busy` and `bit_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Generator enable; low aborts and mutes |
| start | input | 1 | Start command (one-cycle pulse) |
| mark_hold | input | 1 | Keep sending marks after a segment |
| chan_sel | input | 2 | Channel the stream is routed to |
| seize_pairs | input | 8 | Seizure length in 0/1 pairs |
| mark_bits | input | 8 | Mark run length in bits |
| flag_bits | input | 8 | Flag run after each byte, in bits |
| byte_count | input | 8 | Bytes in this segment (capped at 64) |
| baud_tick | input | 1 | One-cycle strobe per bit period |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | 6 | Buffer write address |
| wr_data | input | 8 | Buffer write byte |
| bit_out | output | 1 | Current serial bit |
| bit_valid | output | 1 | Stream active (low = muted) |
| chan_valid | output | 4 | Per-channel valid, one-hot or zero |
| busy | output | 1 | Seizure, mark or byte loop in progress |
| done | output | 1 | One-cycle pulse at segment end |

## Verification
The bench covers several zero-length cases: a missing seizure, a missing mark run, no flags and no bytes. A design that did not skip those phases would insert a spurious bit or hang waiting on a zero counter. A count of 70 is used to check that only 64 bytes are sent; a missing cap would read past the buffer and lengthen the stream. Byte contents with unequal end bits expose MSB-first shifting. The hold tests clear mark-hold and then set it again, because a design that reads the live input instead of an armed copy would wrongly resume marks. Stopping the tick exposes a stream that advances on the clock instead of on the strobe.

// File: rtl/cid_fsk_pkg.sv
package cid_fsk_pkg;

    localparam int BUF_DEPTH = 64;
    localparam int BYTE_W    = 8;
    localparam int LEN_W     = 8;
    localparam int CHANNELS  = 4;
    localparam int ADDR_W    = $clog2(BUF_DEPTH);
    localparam int TOT_W     = ADDR_W + 1;
    localparam int CH_W      = $clog2(CHANNELS);
    localparam int CNT_W     = LEN_W + 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEIZE,
        PH_MARK,
        PH_START,
        PH_DATA,
        PH_STOP,
        PH_FLAG,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [LEN_W-1:0] seize_pairs;
        logic [LEN_W-1:0] mark_bits;
        logic [LEN_W-1:0] flag_bits;
        logic [TOT_W-1:0] byte_total;
        logic [CH_W-1:0]  chan;
    } frame_cfg_t;

    function automatic logic [TOT_W-1:0] clamp_total(input logic [LEN_W-1:0] n);
        if (n > LEN_W'(BUF_DEPTH))
            return TOT_W'(BUF_DEPTH);
        return n[TOT_W-1:0];
    endfunction

    // PH_IDLE returned by these helpers means "segment finished"
    function automatic phase_e after_mark(input logic more);
        return more ? PH_START : PH_IDLE;
    endfunction

    function automatic phase_e after_seize(input frame_cfg_t c, input logic more);
        return (c.mark_bits != '0) ? PH_MARK : after_mark(more);
    endfunction

    function automatic phase_e after_stop(input frame_cfg_t c, input logic more);
        return (c.flag_bits != '0) ? PH_FLAG : after_mark(more);
    endfunction

    function automatic phase_e first_phase(input frame_cfg_t c);
        return (c.seize_pairs != '0) ? PH_SEIZE : after_seize(c, c.byte_total != '0);
    endfunction

endpackage

// File: rtl/cid_fsk_msgbuf.sv
module cid_fsk_msgbuf
    import cid_fsk_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    parameter int WIDTH = BYTE_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cid_fsk_framer.sv
module cid_fsk_framer
    import cid_fsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              start,
    input  logic              mark_hold,
    input  frame_cfg_t        cfg_in,
    input  logic              baud_tick,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              bit_out,
    output logic              bit_valid,
    output logic              busy,
    output logic              done,
    output logic [CH_W-1:0]   chan
);

    phase_e            phase, phase_nx;
    frame_cfg_t        cfg_q;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic [TOT_W-1:0]  idx, idx_nx;
    logic [BYTE_W-1:0] shreg;
    logic              load_byte;
    logic              hold_armed;
    logic              accept;
    logic              seg_end;
    logic              active;
    phase_e            entry;

    assign active = (phase != PH_IDLE) && (phase != PH_HOLD);
    assign accept = enable && start && !active;
    assign entry  = first_phase(cfg_in);

    // Tick-driven advance through the frame
    always_comb begin
        phase_nx  = phase;
        cnt_nx    = cnt;
        idx_nx    = idx;
        load_byte = 1'b0;
        if (baud_tick) begin
            unique case (phase)
                PH_SEIZE: begin
                    if (cnt == {cfg_q.seize_pairs - 1'b1, 1'b1}) begin
                        phase_nx = after_seize(cfg_q, cfg_q.byte_total != '0);
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                PH_MARK: begin
                    if (cnt == {1'b0, cfg_q.mark_bits - 1'b1}) begin
                        phase_nx = after_mark(cfg_q.byte_total != '0);
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                PH_START: begin
                    phase_nx  = PH_DATA;
                    cnt_nx    = '0;
                    load_byte = 1'b1;
                end
                PH_DATA: begin
                    if (cnt == CNT_W'(BYTE_W - 1)) begin
                        phase_nx = PH_STOP;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                PH_STOP: begin
                    phase_nx = after_stop(cfg_q, (idx + 1'b1) < cfg_q.byte_total);
                    idx_nx   = idx + 1'b1;
                    cnt_nx   = '0;
                end
                PH_FLAG: begin
                    if (cnt == {1'b0, cfg_q.flag_bits - 1'b1}) begin
                        phase_nx = after_mark(idx < cfg_q.byte_total);
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign seg_end = active && (phase_nx == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cfg_q      <= '0;
            cnt        <= '0;
            idx        <= '0;
            shreg      <= '0;
            hold_armed <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                phase      <= PH_IDLE;
                hold_armed <= 1'b0;
            end else if (accept) begin
                cfg_q      <= cfg_in;
                cnt        <= '0;
                idx        <= '0;
                hold_armed <= mark_hold;
                if (entry == PH_IDLE) begin
                    done  <= 1'b1;
                    phase <= mark_hold ? PH_HOLD : PH_IDLE;
                end else begin
                    phase <= entry;
                end
            end else begin
                if (!mark_hold)
                    hold_armed <= 1'b0;
                if (phase == PH_HOLD && !(hold_armed && mark_hold))
                    phase <= PH_IDLE;
                else if (seg_end) begin
                    phase <= (hold_armed && mark_hold) ? PH_HOLD : PH_IDLE;
                    done  <= 1'b1;
                end else begin
                    phase <= phase_nx;
                end
                cnt <= cnt_nx;
                idx <= idx_nx;
                if (load_byte)
                    shreg <= rd_data;
            end
        end
    end

    always_comb begin
        unique case (phase)
            PH_IDLE:  bit_out = 1'b0;
            PH_SEIZE: bit_out = cnt[0];
            PH_START: bit_out = 1'b0;
            PH_DATA:  bit_out = shreg[cnt[2:0]];
            default:  bit_out = 1'b1;
        endcase
    end

    assign bit_valid = (phase != PH_IDLE);
    assign busy      = active;
    assign rd_addr   = idx[ADDR_W-1:0];
    assign chan      = cfg_q.chan;

    // R11
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!baud_tick && !accept && busy && enable) |=> $stable(bit_out));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9
    hold_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_armed && !accept) |=> !hold_armed);

    // R12
    abort_mute_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!bit_valid && !busy));

endmodule

// File: rtl/cid_fsk_router.sv
module cid_fsk_router
    import cid_fsk_pkg::*;
#(
    parameter int NCH  = CHANNELS,
    localparam int SW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           valid,
    input  logic [SW-1:0]  sel,
    output logic [NCH-1:0] chan_valid
);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign chan_valid[k] = valid && (sel == SW'(k));
    end

    // R10
    chan_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_valid));

    // R10
    chan_match_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_valid != '0) == valid);

endmodule

// File: rtl/cid_fsk_sequencer.sv
module cid_fsk_sequencer
    import cid_fsk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                start,
    input  logic                mark_hold,
    input  logic [CH_W-1:0]     chan_sel,
    input  logic [LEN_W-1:0]    seize_pairs,
    input  logic [LEN_W-1:0]    mark_bits,
    input  logic [LEN_W-1:0]    flag_bits,
    input  logic [LEN_W-1:0]    byte_count,
    input  logic                baud_tick,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic                bit_out,
    output logic                bit_valid,
    output logic [CHANNELS-1:0] chan_valid,
    output logic                busy,
    output logic                done
);

    frame_cfg_t        cfg_in;
    logic [ADDR_W-1:0] rd_addr;
    logic [BYTE_W-1:0] rd_data;
    logic [CH_W-1:0]   chan_q;

    always_comb begin
        cfg_in.seize_pairs = seize_pairs;
        cfg_in.mark_bits   = mark_bits;
        cfg_in.flag_bits   = flag_bits;
        cfg_in.byte_total  = clamp_total(byte_count);
        cfg_in.chan        = chan_sel;
    end

    cid_fsk_msgbuf #(.DEPTH(BUF_DEPTH), .WIDTH(BYTE_W)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    cid_fsk_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .start     (start),
        .mark_hold (mark_hold),
        .cfg_in    (cfg_in),
        .baud_tick (baud_tick),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .bit_out   (bit_out),
        .bit_valid (bit_valid),
        .busy      (busy),
        .done      (done),
        .chan      (chan_q)
    );

    cid_fsk_router #(.NCH(CHANNELS)) u_router (
        .clk        (clk),
        .rst        (rst),
        .valid      (bit_valid),
        .sel        (chan_q),
        .chan_valid (chan_valid)
    );

endmodule

// File: tb/cid_fsk_sequencer_bench.sv
module cid_fsk_sequencer_bench;

    localparam int CAP_MAX = 1024;
    localparam int NVEC    = 5;
    // {seize_pairs, mark_bits, flag_bits, byte_count}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd4,  8'd6,  8'd3, 8'd3},
        {8'd0,  8'd5,  8'd0, 8'd2},
        {8'd2,  8'd0,  8'd2, 8'd0},
        {8'd1,  8'd2,  8'd1, 8'd70},
        {8'd16, 8'd32, 8'd8, 8'd4}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0, start = 1'b0, mark_hold = 1'b0;
    logic [1:0] chan_sel = '0;
    logic [7:0] seize_pairs = '0, mark_bits = '0, flag_bits = '0, byte_count = '0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       bit_out, bit_valid, busy, done;
    logic [3:0] chan_valid;

    logic       tick_on = 1'b0;
    int         tick_div = 0;
    logic       cap [CAP_MAX];
    int         cap_n = 0;
    logic       expv [CAP_MAX];
    int         exp_n = 0;
    logic [7:0] msg [64];
    int         tests = 0, fails = 0;
    bit         finished = 0;

    cid_fsk_sequencer u_cid_fsk_sequencer (
        .clk(clk), .rst(rst), .enable(enable), .start(start), .mark_hold(mark_hold),
        .chan_sel(chan_sel), .seize_pairs(seize_pairs), .mark_bits(mark_bits),
        .flag_bits(flag_bits), .byte_count(byte_count), .baud_tick(baud_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .bit_out(bit_out),
        .bit_valid(bit_valid), .chan_valid(chan_valid), .busy(busy), .done(done)
    );

    always #2 clk = ~clk;

    // Tick driver and bit capture: a bit is recorded when a tick is about to consume it
    initial begin
        forever begin
            @(negedge clk);
            if (tick_on) begin
                tick_div = (tick_div + 1) % 3;
                baud_tick = (tick_div == 0);
            end else begin
                baud_tick = 1'b0;
            end
            if (baud_tick && busy) begin
                if (cap_n < CAP_MAX) cap[cap_n] = bit_out;
                cap_n++;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic push(input logic b);
        if (exp_n < CAP_MAX) expv[exp_n] = b;
        exp_n++;
    endtask

    task automatic build_expected(input int p, input int m, input int f, input int n);
        int nb;
        exp_n = 0;
        nb = (n > 64) ? 64 : n;
        for (int i = 0; i < 2 * p; i++) push(logic'(i % 2));
        for (int i = 0; i < m; i++) push(1'b1);
        for (int b = 0; b < nb; b++) begin
            push(1'b0);
            for (int k = 0; k < 8; k++) push(msg[b][k]);
            push(1'b1);
            for (int i = 0; i < f; i++) push(1'b1);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(req, "done pulse seen", int'(done), 1);
    endtask

    task automatic setup(input int p, input int m, input int f, input int n, input int ch);
        seize_pairs = 8'(p);
        mark_bits   = 8'(m);
        flag_bits   = 8'(f);
        byte_count  = 8'(n);
        chan_sel    = 2'(ch);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) msg[i] = 8'((i * 37 + 5) ^ (i << 5));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "bit_valid/bit_out/done", int'({bit_valid, bit_out, done}), 0);
        chk("R1", "chan_valid", int'(chan_valid), 0);
        rst = 1'b0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 6'(i); wr_data = msg[i];
        end
        @(negedge clk);
        wr_en = 1'b0;

        // R2: start ignored while disabled
        setup(2, 2, 1, 1, 0);
        pulse_start();
        repeat (4) @(negedge clk);
        chk("R2", "busy after disabled start", int'(busy), 0);
        chk("R2", "bit_valid after disabled start", int'(bit_valid), 0);

        enable = 1'b1;
        tick_on = 1'b1;
        // Table walk: R3 R4 R5 R6 R7 R10
        for (int v = 0; v < NVEC; v++) begin
            setup(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]),
                  int'(VEC[v][7:0]), v % 4);
            build_expected(int'(VEC[v][31:24]), int'(VEC[v][23:16]),
                           int'(VEC[v][15:8]), int'(VEC[v][7:0]));
            cap_n = 0;
            pulse_start();
            chk("R10", "chan_valid while sending", int'(chan_valid), 1 << (v % 4));
            wait_done("R7");
            chk("R7", "busy at done", int'(busy), 0);
            chk("R6", "bit count", cap_n, exp_n);
            begin
                int bad;
                bad = 0;
                for (int i = 0; i < exp_n && i < cap_n; i++)
                    if (cap[i] !== expv[i]) bad++;
                chk("R5", "mismatched bits (R3 R4 framing)", bad, 0);
            end
            @(negedge clk);
            chk("R7", "muted after segment", int'(bit_valid), 0);
        end

        // R11: no tick, bit holds; R12: abort on enable drop
        tick_on = 1'b0;
        setup(3, 2, 1, 1, 2);
        pulse_start();
        chk("R2", "busy after enabled start", int'(busy), 1);
        repeat (10) @(negedge clk);
        chk("R11", "first seizure bit held without tick", int'(bit_out), 0);
        chk("R11", "still busy without tick", int'(busy), 1);
        enable = 1'b0;
        @(negedge clk);
        chk("R12", "busy/valid after enable drop", int'({busy, bit_valid}), 0);
        enable = 1'b1;
        tick_on = 1'b1;

        // R8: mark-hold after segment
        mark_hold = 1'b1;
        setup(1, 2, 1, 2, 3);
        pulse_start();
        wait_done("R8");
        repeat (10) @(negedge clk);
        chk("R8", "hold valid/bit/busy", int'({bit_valid, bit_out, busy}), 6);
        chk("R8", "hold channel", int'(chan_valid), 8);
        mark_hold = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8", "muted after hold cleared", int'(bit_valid), 0);
        // R9: re-raising hold has no effect
        mark_hold = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9", "re-raised hold stays muted", int'(bit_valid), 0);
        // R9: cleared then set during transmission, still muted at end
        setup(1, 3, 0, 1, 1);
        pulse_start();
        mark_hold = 1'b0;
        repeat (2) @(negedge clk);
        mark_hold = 1'b1;
        wait_done("R9");
        @(negedge clk);
        chk("R9", "hold re-raised mid segment ignored", int'(bit_valid), 0);
        // New start re-arms hold
        pulse_start();
        wait_done("R9");
        @(negedge clk);
        chk("R9", "hold re-armed by new start", int'({bit_valid, bit_out}), 3);
        mark_hold = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", "final mute", int'(bit_valid), 0);

        summary();
    end

endmodule